// File: doc/BRIEF.md
# Routed Interrupt Sense Controller

This block collects up to 32 external interrupt sources and delivers them to a set of numbered output lines or to two special outputs: a non-maskable line and a fast-interrupt line. Each source has its own sense configuration: active polarity, level or edge sensing, and an optional mode that latches both transitions. Software reaches the block through a simple 32-bit register port made of an address, a write strobe, write data and combinational read data.

Each source passes through a two-flop synchronizer. A third flop holds the previous synchronized value for edge detection. Each source has a two-state latch FSM with the states `LATCH_CLEAR` and `LATCH_HELD`. The latch moves from `LATCH_CLEAR` to `LATCH_HELD` on a qualifying edge or on a set command. It moves from `LATCH_HELD` back to `LATCH_CLEAR` on a clear command, but only if no edge arrives in the same cycle.

A level-sensed source is pending while its polarity-adjusted synchronized input is active. An edge-sensed source is pending while its latch is held. Enables are changed through a write-one-to-set word and a write-one-to-clear word, and are read back through a read-only view. Each source has a routing word that selects where it goes. A source that is pending and enabled drives the output its routing word selects.

Register layout (byte addresses), with source n at bit n of each per-source word:

| Address | Access | Content |
|---|---|---|
| 0x000 | read/write | polarity |
| 0x004 | read/write | trigger |
| 0x008 | read/write | dual-edge |
| 0x00C | write-only | enable set |
| 0x010 | write-only | enable clear |
| 0x014 | read-only | enable view |
| 0x018 | read-only | pending |
| 0x01C | write-only | edge command |
| 0x100 + 4·n | read/write | routing word of source n |

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, all of the following are 0: polarity, trigger, dual-edge, enables and every routing word. `line_irq`, `nmi_irq` and `fast_irq` are also 0.
- R2: Writing to 0x00C enables each source whose data bit is 1. Writing to 0x010 disables each source whose data bit is 1. Zero bits in either write leave the enable unchanged. Address 0x014 reads back the current enables.
- R3: For a level-sensed source (trigger bit 0), the pending bit at 0x018 equals the input when polarity is 1, and the inverted input when polarity is 0. A change on the input shows up in the pending bit after exactly two rising clock edges.
- R4: An edge-sensed source (trigger bit 1, dual-edge bit 0) latches pending on a rising input when polarity is 1, and on a falling input when polarity is 0. The opposite transition does not set it. The latched pending stays set after the input returns.
- R5: An edge-sensed source with its dual-edge bit set latches pending on both rising and falling transitions.
- R6: A write to 0x01C addresses the source numbered by data bits 4:0. Bit 31 = 1 sets that source's edge latch, and bit 31 = 0 clears it.
- R7: In a routing word, bit 31 selects a numbered line and bits 5:0 hold the line number. When any source routed to a line is pending and enabled, that `line_irq` bit is 1.
- R8: Routing bit 30 selects `nmi_irq` and bit 29 selects `fast_irq`. NMI takes priority over fast, and fast takes priority over the numbered line. A word with none of bits 31:29 set drives no output.
- R9: A source that is disabled drives no output, even while its pending bit reads 1.
- R10: Polarity, trigger and dual-edge read back as written. A routing word reads back bits 31, 30, 29 and 5:0 as written, and every other bit reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| src_in | input | 32 | Asynchronous interrupt source inputs |
| line_irq | output | 64 | Numbered interrupt output lines |
| nmi_irq | output | 1 | Non-maskable interrupt output |
| fast_irq | output | 1 | Fast-interrupt output |

## Verification
The assertions assume the following about the inputs:
- At most one register write occurs per cycle, so a set and a clear of the same enable cannot coincide.
- Any edge command that a latch assertion relies on names a source below the source count.
- Source inputs hold each value for at least one full clock period, so the synchronizer sees every transition.

The stimulus respects these by driving every write and every input change at the falling clock edge, with each change held for one or more cycles. Only legal source numbers are used in edge commands.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef struct packed {
        logic       to_line;
        logic       to_nmi;
        logic       to_fast;
        logic [5:0] line;
    } route_t;

    typedef enum logic {
        LATCH_CLEAR = 1'b0,
        LATCH_HELD  = 1'b1
    } latch_st_e;

    localparam int unsigned OFS_POL     = 'h000;
    localparam int unsigned OFS_TRIG    = 'h004;
    localparam int unsigned OFS_DUAL    = 'h008;
    localparam int unsigned OFS_EN_SET  = 'h00C;
    localparam int unsigned OFS_EN_CLR  = 'h010;
    localparam int unsigned OFS_EN_VIEW = 'h014;
    localparam int unsigned OFS_PEND    = 'h018;
    localparam int unsigned OFS_EDGE    = 'h01C;
    localparam int unsigned OFS_ROUTE   = 'h100;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_route_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic pol,
    input  logic edge_mode,
    input  logic dual,
    input  logic cmd_set,
    input  logic cmd_clr,
    output logic pending
);
    logic      sync1_q, sync2_q, prev_q;
    logic      rise, fall, hit;
    latch_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= raw_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign rise = sync2_q & ~prev_q;
    assign fall = ~sync2_q & prev_q;
    assign hit  = edge_mode & (dual ? (rise | fall) : (pol ? rise : fall));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LATCH_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LATCH_CLEAR: if (hit || cmd_set) state_d = LATCH_HELD;
            LATCH_HELD:  if (cmd_clr && !cmd_set && !hit) state_d = LATCH_CLEAR;
        endcase
    end

    assign pending = edge_mode ? (state_q == LATCH_HELD) : (pol ? sync2_q : ~sync2_q);

    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (state_q == LATCH_HELD)) else $error("edge lost"); // R4
    AST_CMD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_set |=> (state_q == LATCH_HELD)) else $error("set lost"); // R6
    AST_CMD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clr && !cmd_set && !hit) |=> (state_q == LATCH_CLEAR)) else $error("clear lost"); // R6

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       we,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    input  logic [NUM_SRC-1:0]         pend,
    output logic [NUM_SRC-1:0]         pol_q,
    output logic [NUM_SRC-1:0]         trig_q,
    output logic [NUM_SRC-1:0]         dual_q,
    output logic [NUM_SRC-1:0]         en_q,
    output route_t [NUM_SRC-1:0]       route_q,
    output logic [NUM_SRC-1:0]         cmd_set,
    output logic [NUM_SRC-1:0]         cmd_clr
);
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic               wr_pol, wr_trig, wr_dual, wr_set, wr_clr, wr_edge;
    logic [NUM_SRC-1:0] wsrc;

    assign wsrc    = wdata[NUM_SRC-1:0];
    assign wr_pol  = we && (addr == ADDR_W'(OFS_POL));
    assign wr_trig = we && (addr == ADDR_W'(OFS_TRIG));
    assign wr_dual = we && (addr == ADDR_W'(OFS_DUAL));
    assign wr_set  = we && (addr == ADDR_W'(OFS_EN_SET));
    assign wr_clr  = we && (addr == ADDR_W'(OFS_EN_CLR));
    assign wr_edge = we && (addr == ADDR_W'(OFS_EDGE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q   <= '0;
            trig_q  <= '0;
            dual_q  <= '0;
            en_q    <= '0;
            route_q <= '0;
        end else begin
            if (wr_pol)  pol_q  <= wsrc;
            if (wr_trig) trig_q <= wsrc;
            if (wr_dual) dual_q <= wsrc;
            if (wr_set)  en_q   <= en_q | wsrc;
            if (wr_clr)  en_q   <= en_q & ~wsrc;
            for (int i = 0; i < NUM_SRC; i++) begin
                if (we && addr == ADDR_W'(OFS_ROUTE + 4 * i))
                    route_q[i] <= '{to_line: wdata[31], to_nmi: wdata[30],
                                    to_fast: wdata[29], line: wdata[5:0]};
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            cmd_set[i] = wr_edge && (wdata[SRC_W-1:0] == SRC_W'(i)) &&  wdata[31];
            cmd_clr[i] = wr_edge && (wdata[SRC_W-1:0] == SRC_W'(i)) && !wdata[31];
        end
    end

    always_comb begin
        rdata = '0;
        if      (addr == ADDR_W'(OFS_POL))     rdata[NUM_SRC-1:0] = pol_q;
        else if (addr == ADDR_W'(OFS_TRIG))    rdata[NUM_SRC-1:0] = trig_q;
        else if (addr == ADDR_W'(OFS_DUAL))    rdata[NUM_SRC-1:0] = dual_q;
        else if (addr == ADDR_W'(OFS_EN_VIEW)) rdata[NUM_SRC-1:0] = en_q;
        else if (addr == ADDR_W'(OFS_PEND))    rdata[NUM_SRC-1:0] = pend;
        else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (addr == ADDR_W'(OFS_ROUTE + 4 * i))
                    rdata = {route_q[i].to_line, route_q[i].to_nmi, route_q[i].to_fast,
                             {(DATA_W-9){1'b0}}, route_q[i].line};
            end
        end
    end

    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((en_q & $past(wsrc)) == $past(wsrc))) else $error("set failed"); // R2
    AST_ENABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((en_q & $past(wsrc)) == '0)) else $error("clear failed"); // R2

endmodule

// File: rtl/irq_route_fabric.sv
module irq_route_fabric
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   act,
    input  route_t [NUM_SRC-1:0] route,
    output logic [NUM_LINES-1:0] lines,
    output logic                 nmi,
    output logic                 fast
);
    localparam int LINE_IW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    always_comb begin
        lines = '0;
        nmi   = 1'b0;
        fast  = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (act[i]) begin
                if (route[i].to_nmi)       nmi  = 1'b1;
                else if (route[i].to_fast) fast = 1'b1;
                else if (route[i].to_line && int'(route[i].line) < NUM_LINES)
                    lines[route[i].line[LINE_IW-1:0]] = 1'b1;
            end
        end
    end

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> (lines == '0 && !nmi && !fast)) else $error("spurious output"); // R9

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_SRC-1:0]   src_in,
    output logic [NUM_LINES-1:0] line_irq,
    output logic                 nmi_irq,
    output logic                 fast_irq
);
    logic [NUM_SRC-1:0]   pol, trig, dual, en, pend, cset, cclr;
    route_t [NUM_SRC-1:0] route;

    irq_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk, .rst_n, .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .rdata(bus_rdata), .pend, .pol_q(pol), .trig_q(trig), .dual_q(dual),
        .en_q(en), .route_q(route), .cmd_set(cset), .cmd_clr(cclr)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_src_cell u_cell (
            .clk, .rst_n, .raw_in(src_in[g]), .pol(pol[g]), .edge_mode(trig[g]),
            .dual(dual[g]), .cmd_set(cset[g]), .cmd_clr(cclr[g]), .pending(pend[g])
        );
    end

    irq_route_fabric #(.NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES)) u_fabric (
        .clk, .rst_n, .act(pend & en), .route, .lines(line_irq),
        .nmi(nmi_irq), .fast(fast_irq)
    );

endmodule

// File: tb/test_irq_route_ctrl.sv
module test_irq_route_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_in = '0;
    logic [63:0] line_irq;
    logic        nmi_irq, fast_irq;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_route_ctrl i_irq_route_ctrl (
        .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
        .src_in, .line_irq, .nmi_irq, .fast_irq
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic pend_bit(input string tag, input int n, input logic exp);
        bus_addr = 12'h018;
        #1;
        chk(tag, 64'(bus_rdata[n]), 64'(exp));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R1 polarity", 12'h000, 32'h0);
        rd_chk("R1 trigger", 12'h004, 32'h0);
        rd_chk("R1 enables", 12'h014, 32'h0);
        rd_chk("R1 route5", 12'h114, 32'h0);
        chk("R1 lines", line_irq, 64'h0);
        chk("R1 nmi/fast", {62'h0, nmi_irq, fast_irq}, 64'h0);
    endtask

    task automatic t_enable;
        wr(12'h00C, 32'h0000_00F0);
        rd_chk("R2 set", 12'h014, 32'h0000_00F0);
        wr(12'h00C, 32'h0);
        rd_chk("R2 set zero no effect", 12'h014, 32'h0000_00F0);
        wr(12'h010, 32'h0000_0030);
        rd_chk("R2 clear", 12'h014, 32'h0000_00C0);
        wr(12'h010, 32'h0);
        rd_chk("R2 clear zero no effect", 12'h014, 32'h0000_00C0);
        wr(12'h010, 32'hFFFF_FFFF);
        rd_chk("R2 clear all", 12'h014, 32'h0);
    endtask

    task automatic t_config_rb;
        wr(12'h000, 32'hA5A5_0001);
        rd_chk("R10 polarity", 12'h000, 32'hA5A5_0001);
        wr(12'h004, 32'h5A5A_1234);
        rd_chk("R10 trigger", 12'h004, 32'h5A5A_1234);
        wr(12'h008, 32'h0F0F_8000);
        rd_chk("R10 dual", 12'h008, 32'h0F0F_8000);
        wr(12'h10C, 32'hFFFF_FFFF);
        rd_chk("R10 route3 fields", 12'h10C, 32'hE000_003F);
        wr(12'h000, 32'h0); wr(12'h004, 32'h0); wr(12'h008, 32'h0); wr(12'h10C, 32'h0);
    endtask

    task automatic t_level;
        wr(12'h000, 32'h0000_0001);
        src_in = '0;
        idle(4);
        pend_bit("R3 high-active idle", 0, 1'b0);
        pend_bit("R3 low-active idle", 1, 1'b1);
        src_in[0] = 1'b1;
        @(negedge clk);
        pend_bit("R3 after one edge", 0, 1'b0);
        @(negedge clk);
        pend_bit("R3 after two edges", 0, 1'b1);
        src_in[1] = 1'b1;
        idle(3);
        pend_bit("R3 low-active driven high", 1, 1'b0);
        src_in = '0;
        idle(3);
    endtask

    task automatic t_edge;
        wr(12'h000, 32'h0000_0011);
        wr(12'h004, 32'h0000_1230);
        wr(12'h01C, 32'h4); wr(12'h01C, 32'h5);
        idle(3);
        pend_bit("R4 initial clear", 4, 1'b0);
        src_in[4] = 1'b1;
        @(negedge clk);
        src_in[4] = 1'b0;
        idle(4);
        pend_bit("R4 rising latched", 4, 1'b1);
        src_in[5] = 1'b1;
        idle(4);
        pend_bit("R4 falling-sense ignores rise", 5, 1'b0);
        src_in[5] = 1'b0;
        idle(4);
        pend_bit("R4 falling latched", 5, 1'b1);
    endtask

    task automatic t_cmd;
        wr(12'h01C, 32'h0000_0004);
        pend_bit("R6 clear src4", 4, 1'b0);
        pend_bit("R6 src5 untouched", 5, 1'b1);
        wr(12'h01C, 32'h8000_0009);
        pend_bit("R6 set src9", 9, 1'b1);
        wr(12'h01C, 32'h0000_0009);
        pend_bit("R6 clear src9", 9, 1'b0);
        wr(12'h01C, 32'h0000_0005);
    endtask

    task automatic t_dual;
        wr(12'h008, 32'h0000_1000);
        wr(12'h01C, 32'h0000_000C);
        src_in[12] = 1'b1;
        idle(4);
        pend_bit("R5 dual rising", 12, 1'b1);
        wr(12'h01C, 32'h0000_000C);
        pend_bit("R5 cleared", 12, 1'b0);
        src_in[12] = 1'b0;
        idle(4);
        pend_bit("R5 dual falling", 12, 1'b1);
        wr(12'h01C, 32'h0000_000C);
    endtask

    task automatic t_route;
        wr(12'h100, 32'h8000_0025);
        wr(12'h00C, 32'h0000_0001);
        src_in[0] = 1'b1;
        idle(4);
        chk("R7 line 37 driven", line_irq, 64'h1 << 37);
        chk("R7 nmi quiet", 64'(nmi_irq), 64'h0);
        src_in[0] = 1'b0;
        idle(4);
        chk("R7 line released", line_irq, 64'h0);
        src_in[0] = 1'b1;
        wr(12'h010, 32'h0000_0001);
        idle(4);
        chk("R9 disabled no line", line_irq, 64'h0);
        pend_bit("R9 still pending", 0, 1'b1);
        wr(12'h00C, 32'h0000_0001);
    endtask

    task automatic t_priority;
        wr(12'h100, 32'hE000_0025);
        #1;
        chk("R8 nmi wins", {line_irq[37], nmi_irq, fast_irq}, 64'b010);
        wr(12'h100, 32'hA000_0025);
        #1;
        chk("R8 fast over line", {line_irq[37], nmi_irq, fast_irq}, 64'b001);
        wr(12'h100, 32'h0000_0025);
        #1;
        chk("R8 no select", {line_irq[37], nmi_irq, fast_irq}, 64'b000);
        wr(12'h100, 32'h4000_0000);
        #1;
        chk("R8 nmi only", {line_irq[37], nmi_irq, fast_irq}, 64'b010);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        idle(2);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_enable();
        t_config_rb();
        t_level();
        t_edge();
        t_cmd();
        t_dual();
        t_route();
        t_priority();
        summary();
    end

endmodule